// File: doc/BRIEF.md
# Saturating Monitor Mix Adder

This block sits in a stereo 16-bit audio path between the capture converters and the playback volume stage. On each sample strobe it takes one left/right pair of capture samples and one left/right pair of playback samples, all 16-bit two's complement. It scales the capture pair down by a shared monitor level and adds it to the playback pair. The two sums go on to the playback attenuator. The capture samples sent to the host are not touched.

The monitor level is a 4-bit code. Each step lowers the monitor signal by 6 dB, which the block does as an arithmetic right shift with sign extension. The all-ones code mutes the monitor path. A separate disable input also forces the monitor path to zero, for example while calibration or analog loopback is running. The sum is formed one bit wider than a sample and then clipped to full scale, so it never wraps. Both channels are handled in the same cycle and their results are registered together.

Top module: `mon_mix_sat`

## Requirements
- R1: While reset is high and in the first cycle after it, `out_vld` is 0 and both `mix_l` and `mix_r` are 0.
- R2: `out_vld` is high in the cycle after the one in which `in_vld` was sampled high, and low otherwise. Both channel results update in that same cycle.
- R3: With monitor code 0 and `mon_off` low, each mix output equals the playback sample plus the capture sample of the same channel, both read as signed 16-bit values, clipped as in R7 and R8.
- R4: With monitor code k from 1 to 14, the capture sample is arithmetically shifted right by k bits before the addition. This equals floor(capture / 2^k), so a negative sample never shifts to a positive or zero value (for example, -1 stays -1).
- R5: Monitor code 15 (binary 1111) mutes the monitor path, and each mix output equals its playback sample.
- R6: When `mon_off` is high, each mix output equals its playback sample, whatever the monitor code is.
- R7: A sum above 32767 gives 32767 (0x7FFF).
- R8: A sum below -32768 gives -32768 (0x8000).
- R9: One monitor code scales both channels. The left result depends only on left inputs and the right result only on right inputs.
- R10: In cycles where `in_vld` is low, `mix_l` and `mix_r` keep their previous values, even if the sample, code or disable inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Sample strobe for all four input samples |
| adc_l | input | 16 | Left capture sample, two's complement |
| adc_r | input | 16 | Right capture sample, two's complement |
| dac_l | input | 16 | Left playback sample, two's complement |
| dac_r | input | 16 | Right playback sample, two's complement |
| mon_code | input | 4 | Shared monitor attenuation code; 6 dB per step; 15 mutes |
| mon_off | input | 1 | Forces the monitor contribution to zero |
| out_vld | output | 1 | Result strobe, one cycle after `in_vld` |
| mix_l | output | 16 | Left mixed sample, saturated |
| mix_r | output | 16 | Right mixed sample, saturated |

## Verification
Each result is due exactly one clock edge after the strobe that carried its inputs. That edge loads the valid flag and both channel registers together.

The bench keeps its own model and updates it on the same rising edge. The model computes the shift as a floor division and the clipping with integers. The bench compares the model against the outputs at every falling edge, so each comparison falls half a cycle after the edge that should have produced the value.

Cycles with the strobe low change the sample, code and disable inputs deliberately. In those cycles the model expects the previous values, so a register that loads without the strobe shows up in the very next comparison.

// File: rtl/mon_mix_pkg.sv
package mon_mix_pkg;
  localparam int MM_LANES = 2;
  localparam int LANE_L   = 0;
  localparam int LANE_R   = 1;
endpackage

// File: rtl/mon_atten.sv
module mon_atten #(
  parameter int SAMPLE_W = 16,
  parameter int CODE_W   = 4
) (
  input  logic [SAMPLE_W-1:0] smp_in,
  input  logic [CODE_W-1:0]   code,
  input  logic                kill,
  output logic [SAMPLE_W-1:0] smp_out
);
  logic signed [SAMPLE_W-1:0] shifted;

  // 6 dB per step: arithmetic right shift keeps the sign
  always_comb begin
    shifted = $signed(smp_in) >>> code;
    smp_out = kill ? '0 : shifted;
  end
endmodule

// File: rtl/mon_sat_add.sv
module mon_sat_add #(
  parameter int SAMPLE_W = 16
) (
  input  logic [SAMPLE_W-1:0] op_a,
  input  logic [SAMPLE_W-1:0] op_b,
  output logic [SAMPLE_W-1:0] sum_out
);
  localparam logic [SAMPLE_W-1:0] MAX_V = {1'b0, {(SAMPLE_W-1){1'b1}}};
  localparam logic [SAMPLE_W-1:0] MIN_V = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic [SAMPLE_W:0] wide;
  logic              ovf;

  always_comb begin
    wide = {op_a[SAMPLE_W-1], op_a} + {op_b[SAMPLE_W-1], op_b};
    ovf  = wide[SAMPLE_W] ^ wide[SAMPLE_W-1];
    if (ovf) sum_out = wide[SAMPLE_W] ? MIN_V : MAX_V;
    else     sum_out = wide[SAMPLE_W-1:0];
  end

  // two non-negative operands never give a negative result
  always_comb begin
    if (!op_a[SAMPLE_W-1] && !op_b[SAMPLE_W-1])
      p_no_wrap_pos_r7: assert (!sum_out[SAMPLE_W-1]);
  end

  // two negative operands never give a non-negative result
  always_comb begin
    if (op_a[SAMPLE_W-1] && op_b[SAMPLE_W-1])
      p_no_wrap_neg_r8: assert (sum_out[SAMPLE_W-1]);
  end
endmodule

// File: rtl/mon_mix_lane.sv
module mon_mix_lane #(
  parameter int SAMPLE_W = 16,
  parameter int CODE_W   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [SAMPLE_W-1:0] adc_smp,
  input  logic [SAMPLE_W-1:0] dac_smp,
  input  logic [CODE_W-1:0]   code,
  input  logic                kill,
  output logic [SAMPLE_W-1:0] mix_q
);
  logic [SAMPLE_W-1:0] mon_smp;
  logic [SAMPLE_W-1:0] mix_d;

  mon_atten #(.SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W)) u_atten (
    .smp_in (adc_smp),
    .code   (code),
    .kill   (kill),
    .smp_out(mon_smp)
  );

  mon_sat_add #(.SAMPLE_W(SAMPLE_W)) u_add (
    .op_a   (dac_smp),
    .op_b   (mon_smp),
    .sum_out(mix_d)
  );

  always_ff @(posedge clk) begin
    if (rst)       mix_q <= '0;
    else if (load) mix_q <= mix_d;
  end

  // a muted or disabled monitor passes the playback sample unchanged
  p_kill_pass_r5: assert property (@(posedge clk) disable iff (rst)
    (load && kill) |=> (mix_q == $past(dac_smp)));

  // no strobe, no change
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(mix_q));
endmodule

// File: rtl/mon_mix_sat.sv
module mon_mix_sat
  import mon_mix_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int CODE_W   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_vld,
  input  logic [SAMPLE_W-1:0] adc_l,
  input  logic [SAMPLE_W-1:0] adc_r,
  input  logic [SAMPLE_W-1:0] dac_l,
  input  logic [SAMPLE_W-1:0] dac_r,
  input  logic [CODE_W-1:0]   mon_code,
  input  logic                mon_off,
  output logic                out_vld,
  output logic [SAMPLE_W-1:0] mix_l,
  output logic [SAMPLE_W-1:0] mix_r
);
  localparam logic [CODE_W-1:0] MUTE_CODE = '1;

  logic                kill;
  logic [SAMPLE_W-1:0] adc_a [MM_LANES];
  logic [SAMPLE_W-1:0] dac_a [MM_LANES];
  logic [SAMPLE_W-1:0] mix_a [MM_LANES];

  assign kill          = mon_off || (mon_code == MUTE_CODE);
  assign adc_a[LANE_L] = adc_l;
  assign adc_a[LANE_R] = adc_r;
  assign dac_a[LANE_L] = dac_l;
  assign dac_a[LANE_R] = dac_r;
  assign mix_l         = mix_a[LANE_L];
  assign mix_r         = mix_a[LANE_R];

  for (genvar g = 0; g < MM_LANES; g++) begin : g_lane
    mon_mix_lane #(.SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W)) u_lane (
      .clk    (clk),
      .rst    (rst),
      .load   (in_vld),
      .adc_smp(adc_a[g]),
      .dac_smp(dac_a[g]),
      .code   (mon_code),
      .kill   (kill),
      .mix_q  (mix_a[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) out_vld <= 1'b0;
    else     out_vld <= in_vld;
  end

  p_vld_rise_r2: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld);

  p_vld_low_r2: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !out_vld);

  p_disable_pass_r6: assert property (@(posedge clk) disable iff (rst)
    (in_vld && mon_off) |=> (mix_l == $past(dac_l) && mix_r == $past(dac_r)));
endmodule

// File: tb/mon_mix_sat_bench.sv
module mon_mix_sat_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_vld = 1'b0;
  logic [15:0] adc_l = '0, adc_r = '0, dac_l = '0, dac_r = '0;
  logic [3:0]  mon_code = '0;
  logic        mon_off = 1'b0;
  logic        out_vld;
  logic [15:0] mix_l, mix_r;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 0;
  string tag   = "R1";

  logic        m_vld = 1'b0;
  logic [15:0] m_l = '0, m_r = '0;

  always #2 clk = ~clk;

  mon_mix_sat u_mon_mix_sat (
    .clk(clk), .rst(rst), .in_vld(in_vld),
    .adc_l(adc_l), .adc_r(adc_r), .dac_l(dac_l), .dac_r(dac_r),
    .mon_code(mon_code), .mon_off(mon_off),
    .out_vld(out_vld), .mix_l(mix_l), .mix_r(mix_r)
  );

  function automatic logic [15:0] ref_mix(logic [15:0] a, logic [15:0] d,
                                          logic [3:0] c, logic off);
    int av, dv, p, mon, s;
    av = $signed(a);
    dv = $signed(d);
    p  = 1 << c;
    if (off || c == 4'd15) mon = 0;
    else if (av >= 0)      mon = av / p;
    else                   mon = -(((-av) + p - 1) / p);
    s = dv + mon;
    if (s > 32767)  s = 32767;
    if (s < -32768) s = -32768;
    return s[15:0];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_vld <= 1'b0; m_l <= '0; m_r <= '0;
    end else begin
      m_vld <= in_vld;
      if (in_vld) begin
        m_l <= ref_mix(adc_l, dac_l, mon_code, mon_off);
        m_r <= ref_mix(adc_r, dac_r, mon_code, mon_off);
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_cmp++;
      if (out_vld !== m_vld || mix_l !== m_l || mix_r !== m_r) begin
        n_bad++;
        $display("FAIL %s: vld/l/r actual %b/%h/%h expected %b/%h/%h",
                 tag, out_vld, mix_l, mix_r, m_vld, m_l, m_r);
      end
    end
  end

  task automatic put(string t, logic [15:0] al, logic [15:0] ar,
                     logic [15:0] dl, logic [15:0] dr, logic [3:0] c, logic off);
    @(negedge clk);
    tag = t; in_vld = 1'b1;
    adc_l = al; adc_r = ar; dac_l = dl; dac_r = dr; mon_code = c; mon_off = off;
  endtask

  task automatic idle(string t);
    @(negedge clk);
    tag = t; in_vld = 1'b0;
    adc_l = 16'h1234; adc_r = 16'h8001; dac_l = 16'h7000; dac_r = 16'h9000;
    mon_code = 4'd0; mon_off = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    put("R3", 16'd100, 16'hFF9C, 16'd20, 16'd30, 4'd0, 1'b0);
    put("R4", 16'hFFFF, 16'hFFFF, 16'd5, 16'd5, 4'd3, 1'b0);
    put("R4", 16'h8000, 16'h7FFF, 16'd0, 16'd0, 4'd14, 1'b0);
    put("R4", 16'hFFF9, 16'd7, 16'd0, 16'd0, 4'd1, 1'b0);
    put("R5", 16'h7FFF, 16'h8000, 16'h0102, 16'hFEDC, 4'd15, 1'b0);
    put("R6", 16'h7FFF, 16'h8000, 16'h0304, 16'hFCBA, 4'd2, 1'b1);
    put("R7", 16'h7000, 16'h7FFF, 16'h7000, 16'h0001, 4'd0, 1'b0);
    put("R8", 16'h9000, 16'h8000, 16'h9000, 16'hFFFF, 4'd0, 1'b0);
    put("R7", 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF, 4'd1, 1'b0);
    put("R9", 16'h4000, 16'hC000, 16'h0000, 16'h0000, 4'd2, 1'b0);
    idle("R2");
    idle("R10");
    idle("R10");
    put("R2", 16'd1, 16'd2, 16'd3, 16'd4, 4'd0, 1'b0);
    idle("R10");
    for (int i = 0; i < 400; i++) begin
      if (i % 3 == 2) idle("R10");
      else put("R3", 16'($urandom), 16'($urandom), 16'($urandom),
               16'($urandom), 4'($urandom), 1'($urandom % 5 == 0));
    end
    idle("R2");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule